// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block turns a physical address into the index of the DRAM chip-select row that holds it. Software programs one cumulative upper limit per row, in 64 MiB units, and one channel-mode bit. Each limit marks the top of its row. The row below it ends where its row begins, so the last populated limit is the total installed memory. A row whose limit equals the limit below it holds nothing and is passed over.

The limits live in registers. The address decode is combinational from those registers. A memory controller places the decoder on its request path to pick a chip select, and to flag an address that falls beyond the installed memory. When the block runs two interleaved channels, only the lower half of the rows are in use. Each of those rows is then shared equally by both channels, and the block reports a channel count of two.

Top module: `row_decoder`

## Requirements
- R1: After reset every row limit is zero and the block is in single-channel mode, so no address hits and `chan_cnt` is 1.
- R2: A write with `wr_sel` from 0 to 7 loads bits 6:0 of `wr_data` as the limit of that row. Bit 7 and the bits above it are ignored.
- R3: A write with `wr_sel` equal to 8 loads the channel mode from `wr_data` bit 21 (1 = dual channel). `chan_cnt` is 2 in dual mode and 1 in single mode.
- R4: The address block is `addr[32:26]`. Row i is selected when the block is at or above the limit of row i-1 and below the limit of row i. The lower bound of row 0 is zero.
- R5: A row whose limit equals the limit of the row below it never produces a hit.
- R6: An address whose block is at or above every active row's range deasserts `hit`, and `row_idx` is then 0.
- R7: In dual-channel mode only rows 0 to 3 take part in the decode, so rows 4 to 7 never hit.
- R8: A write changes the decode from the next clock edge on. With `wr_en` low, or with `wr_sel` from 9 to 15, no register changes.
- R9: When programmed limits are not monotonic and several rows match, the lowest row index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select: 0-7 row limits, 8 channel mode |
| wr_data | input | 32 | Write data |
| addr | input | 33 | Physical address to decode |
| row_idx | output | 3 | Selected row, 0 on a miss |
| hit | output | 1 | Address lies inside a populated row |
| chan_cnt | output | 2 | Number of interleaved channels (1 or 2) |

## Verification
The bench builds the block with its default parameters: eight rows, 7-bit limits and a 26-bit grain. This gives a 33-bit address, so every limit from 0 to 127 can be reached, as can the full span of blocks above the top of memory. Directed cases cover the following:
- empty rows between populated ones
- addresses exactly on a limit
- the reserved bit in the write data
- ignored selects
- the one-cycle write latency
- the dual-channel cut at row 4
- a non-monotonic set of limits

Seeded random rounds then program sorted limits that often repeat. Those rounds mix both channel modes and probe random blocks against a bench model of the decode.

// File: rtl/row_decoder_pkg.sv
package row_decoder_pkg;
    typedef enum logic {
        CH_SINGLE = 1'b0,
        CH_DUAL   = 1'b1
    } chan_mode_e;
endpackage

// File: rtl/row_bound_regs.sv
module row_bound_regs
    import row_decoder_pkg::*;
#(
    parameter int NUM_ROWS = 8,
    parameter int BND_W    = 7,
    parameter int SEL_W    = 4,
    parameter int DATA_W   = 32,
    parameter int DUAL_BIT = 21
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [SEL_W-1:0]               wr_sel,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [NUM_ROWS-1:0][BND_W-1:0] bnd,
    output chan_mode_e                     mode
);
    localparam int IDX_W    = $clog2(NUM_ROWS);
    localparam int MODE_SEL = NUM_ROWS;

    typedef struct packed {
        logic [NUM_ROWS-1:0][BND_W-1:0] bnd;
        chan_mode_e                     mode;
    } state_t;

    state_t st_d, st_q;
    logic   unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (int'(wr_sel) < NUM_ROWS) begin
                st_d.bnd[wr_sel[IDX_W-1:0]] = wr_data[BND_W-1:0];
            end else if (int'(wr_sel) == MODE_SEL) begin
                st_d.mode = chan_mode_e'(wr_data[DUAL_BIT]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{bnd: '0, mode: CH_SINGLE};
        end else begin
            st_q <= st_d;
        end
    end

    assign bnd  = st_q.bnd;
    assign mode = st_q.mode;
endmodule

// File: rtl/row_match.sv
module row_match
    import row_decoder_pkg::*;
#(
    parameter int NUM_ROWS = 8,
    parameter int BND_W    = 7
) (
    input  logic [BND_W-1:0]               blk,
    input  logic [NUM_ROWS-1:0][BND_W-1:0] bnd,
    input  chan_mode_e                     mode,
    output logic [NUM_ROWS-1:0]            match
);
    localparam int HALF_ROWS = NUM_ROWS / 2;

    for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
        logic active;
        logic above_lo;
        if (i < HALF_ROWS) begin : g_lower
            assign active = 1'b1;
        end else begin : g_upper
            assign active = (mode == CH_SINGLE);
        end
        if (i == 0) begin : g_first
            assign above_lo = 1'b1;
        end else begin : g_rest
            assign above_lo = (blk >= bnd[i-1]);
        end
        assign match[i] = active && above_lo && (blk < bnd[i]);
    end
endmodule

// File: rtl/row_pick.sv
module row_pick #(
    parameter int NUM_ROWS = 8,
    parameter int IDX_W    = $clog2(NUM_ROWS)
) (
    input  logic [NUM_ROWS-1:0] match,
    output logic [IDX_W-1:0]    idx,
    output logic                hit
);
    always_comb begin
        idx = '0;
        for (int i = NUM_ROWS - 1; i >= 0; i--) begin
            if (match[i]) begin
                idx = IDX_W'(i);
            end
        end
        hit = |match;
    end
endmodule

// File: rtl/row_decoder.sv
module row_decoder
    import row_decoder_pkg::*;
#(
    parameter int NUM_ROWS = 8,
    parameter int BND_W    = 7,
    parameter int GRAIN_SH = 26,
    parameter int SEL_W    = 4,
    parameter int DATA_W   = 32,
    parameter int DUAL_BIT = 21,
    localparam int ADDR_W  = GRAIN_SH + BND_W,
    localparam int IDX_W   = $clog2(NUM_ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  row_idx,
    output logic              hit,
    output logic [1:0]        chan_cnt
);
    logic [NUM_ROWS-1:0][BND_W-1:0] bnd;
    chan_mode_e                     mode;
    logic [BND_W-1:0]               blk;
    logic [NUM_ROWS-1:0]            match;
    logic                           unused_low_addr;

    assign blk             = addr[ADDR_W-1:GRAIN_SH];
    assign unused_low_addr = ^addr[GRAIN_SH-1:0];

    row_bound_regs #(
        .NUM_ROWS (NUM_ROWS),
        .BND_W    (BND_W),
        .SEL_W    (SEL_W),
        .DATA_W   (DATA_W),
        .DUAL_BIT (DUAL_BIT)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .bnd     (bnd),
        .mode    (mode)
    );

    row_match #(
        .NUM_ROWS (NUM_ROWS),
        .BND_W    (BND_W)
    ) u_match (
        .blk   (blk),
        .bnd   (bnd),
        .mode  (mode),
        .match (match)
    );

    row_pick #(
        .NUM_ROWS (NUM_ROWS),
        .IDX_W    (IDX_W)
    ) u_pick (
        .match (match),
        .idx   (row_idx),
        .hit   (hit)
    );

    assign chan_cnt = (mode == CH_DUAL) ? 2'd2 : 2'd1;
endmodule

// File: rtl/row_decoder_chk.sv
module row_decoder_chk #(
    parameter int NUM_ROWS = 8,
    parameter int BND_W    = 7,
    parameter int GRAIN_SH = 26,
    parameter int SEL_W    = 4,
    parameter int DATA_W   = 32,
    parameter int DUAL_BIT = 21,
    localparam int ADDR_W  = GRAIN_SH + BND_W,
    localparam int IDX_W   = $clog2(NUM_ROWS)
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           wr_en,
    input logic [SEL_W-1:0]               wr_sel,
    input logic [DATA_W-1:0]              wr_data,
    input logic [ADDR_W-1:0]              addr,
    input logic [IDX_W-1:0]               row_idx,
    input logic                           hit,
    input logic [1:0]                     chan_cnt,
    input logic [NUM_ROWS-1:0][BND_W-1:0] bnd
);
    localparam int MODE_SEL = NUM_ROWS;
    localparam int HALF     = NUM_ROWS / 2;

    logic [BND_W-1:0] blk;
    logic             mode_wr;

    assign blk     = addr[ADDR_W-1:GRAIN_SH];
    assign mode_wr = wr_en && (int'(wr_sel) == MODE_SEL);

    AST_HIT_BELOW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> blk < bnd[row_idx]); // R4
    AST_HIT_ABOVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && row_idx != '0) |-> blk >= bnd[row_idx - 1'b1]); // R4
    AST_HIT_POPULATED: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && row_idx != '0) |-> bnd[row_idx] != bnd[row_idx - 1'b1]); // R5
    AST_MISS_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> row_idx == '0); // R6
    AST_DUAL_LOW_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && chan_cnt == 2'd2) |-> int'(row_idx) < HALF); // R7
    AST_CHAN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        chan_cnt == 2'd1 || chan_cnt == 2'd2); // R3
    AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> chan_cnt == ($past(wr_data[DUAL_BIT]) ? 2'd2 : 2'd1)); // R3
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr |=> $stable(chan_cnt)); // R8
endmodule

bind row_decoder row_decoder_chk #(
    .NUM_ROWS (NUM_ROWS),
    .BND_W    (BND_W),
    .GRAIN_SH (GRAIN_SH),
    .SEL_W    (SEL_W),
    .DATA_W   (DATA_W),
    .DUAL_BIT (DUAL_BIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .addr     (addr),
    .row_idx  (row_idx),
    .hit      (hit),
    .chan_cnt (chan_cnt),
    .bnd      (bnd)
);

// File: tb/tb_row_decoder.sv
module tb_row_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [32:0] addr = '0;
    logic [2:0]  row_idx;
    logic        hit;
    logic [1:0]  chan_cnt;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 1'b0;
    int   m_bnd [8];
    bit   m_dual = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    row_decoder dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .addr     (addr),
        .row_idx  (row_idx),
        .hit      (hit),
        .chan_cnt (chan_cnt)
    );

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic void model(input int blk, output bit h, output int idx);
        int lim = m_dual ? 4 : 8;
        h = 1'b0;
        idx = 0;
        for (int i = lim - 1; i >= 0; i--) begin
            int lo = (i == 0) ? 0 : m_bnd[i-1];
            if (blk >= lo && blk < m_bnd[i]) begin
                h = 1'b1;
                idx = i;
            end
        end
    endfunction

    task automatic probe(string req, int blk);
        bit h;
        int idx;
        addr = {blk[6:0], 26'($urandom)};
        #1;
        model(blk, h, idx);
        chk({req, " hit"}, int'(hit), int'(h));
        chk({req, " row"}, int'(row_idx), idx);
    endtask

    task automatic wr(int sel, logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1;
        wr_sel = sel[3:0];
        wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel < 8) m_bnd[sel] = int'(data[6:0]);
        else if (sel == 8) m_dual = data[21];
    endtask

    task automatic load(int b0, int b1, int b2, int b3, int b4, int b5, int b6, int b7);
        int v [8] = '{b0, b1, b2, b3, b4, b5, b6, b7};
        for (int i = 0; i < 8; i++) wr(i, 32'(v[i]) | ($urandom & 32'hFFFF_FF80));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 8; i++) m_bnd[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 chan", int'(chan_cnt), 1);
        probe("R1", 0);
        probe("R1", 77);

        // R2 reserved bits ignored; R4 R5 R6 decode
        load(2, 5, 5, 9, 12, 12, 12, 20);
        probe("R4", 0);
        probe("R4", 1);
        probe("R4", 2);
        probe("R4", 4);
        probe("R5", 5);
        probe("R4", 8);
        probe("R4", 9);
        probe("R5", 12);
        probe("R4", 19);
        probe("R6", 20);
        probe("R6", 127);
        chk("R2 row7 via top", int'(hit), 0);

        // R8 write latency
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 4'd0; wr_data = 32'd1;
        addr = {7'd1, 26'd0};
        #1;
        chk("R8 before edge row", int'(row_idx), 0);
        @(negedge clk);
        wr_en = 1'b0;
        m_bnd[0] = 1;
        probe("R8 after edge", 1);
        // R8 ignored writes
        @(negedge clk); wr_sel = 4'd0; wr_data = 32'd100;
        @(negedge clk);
        for (int s = 9; s < 16; s++) begin
            @(negedge clk); wr_en = 1'b1; wr_sel = s[3:0]; wr_data = 32'hFFFF_FFFF;
        end
        @(negedge clk); wr_en = 1'b0;
        chk("R8 chan untouched", int'(chan_cnt), 1);
        probe("R8 untouched", 1);
        probe("R8 untouched", 15);

        // R3 R7 dual mode
        wr(8, 32'h0020_0000);
        chk("R3 dual chan", int'(chan_cnt), 2);
        probe("R7", 8);
        probe("R7", 9);
        probe("R7", 15);
        wr(8, 32'hFFDF_FFFF);
        chk("R3 single chan", int'(chan_cnt), 1);
        probe("R7 back", 15);

        // R9 non-monotonic
        load(10, 4, 8, 8, 30, 30, 30, 30);
        probe("R9", 5);
        probe("R9", 9);
        probe("R9", 10);
        probe("R9", 29);

        // random rounds
        for (int r = 0; r < 30; r++) begin
            int acc = 0;
            int v [8];
            for (int i = 0; i < 8; i++) begin
                acc += ($urandom_range(0, 2) == 0) ? 0 : int'($urandom_range(1, 20));
                if (acc > 127) acc = 127;
                v[i] = acc;
            end
            load(v[0], v[1], v[2], v[3], v[4], v[5], v[6], v[7]);
            wr(8, $urandom);
            chk("R3 rand chan", int'(chan_cnt), m_dual ? 2 : 1);
            for (int k = 0; k < 40; k++) probe("R4 rand", int'($urandom_range(0, 127)));
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule